// File: doc/BRIEF.md
# Framed Four-Bit Pattern Recognizer

The block watches a serial bit stream, one bit per cycle in which the valid qualifier is high, and cuts it into back-to-back groups of four bits that do not overlap. A group ends with its fourth valid bit, and the next valid bit begins a new group. When a group ends, the block decides whether that group was one of the two accepted words, `1010` or `0110`. In both words the leftmost bit is the first bit received.

The decision appears on a single registered Moore output. It rises on the clock edge that takes in the fourth bit of a matching group. It stays high through any following cycles with valid low, and falls on the edge that takes in the next valid bit. The machine has eight states. Seven of them track position within the group and whether the group can still match. The eighth is a second start-of-group state that carries the hit. The state register can be built with a binary code or a one-hot code, chosen by a parameter.

Top module: `frame_pattern_recognizer`

## Requirements
- R1: While rst_ni is low, match_o is 0. Releasing reset starts a new group, even if reset was applied in the middle of a group.
- R2: A group received as 1, 0, 1, 0 (first bit leftmost, word `1010`) drives match_o to 1 after its fourth valid bit.
- R3: A group received as 0, 1, 1, 0 (word `0110`) drives match_o to 1 after its fourth valid bit.
- R4: Each of the other fourteen four-bit groups leaves match_o at 0 after its fourth valid bit.
- R5: Groups never overlap. An accepted word that straddles a group boundary is not reported, and match_o can rise only on a group boundary.
- R6: match_o is 0 after the first, second and third valid bits of every group. After a hit, match_o falls on the edge that takes in the next valid bit.
- R7: A cycle with valid_i low changes neither the state nor match_o.
- R8: A group ruled out by its early bits is still counted to its full four bits, so the following group keeps its framing.
- R9: Consecutive matching groups with no gap between them each produce their own hit.
- R10: The stream 0010 0110 1100 1010 0011 produces match_o high only after the 8th bit and after the 16th bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | bit_i carries a stream bit this cycle |
| bit_i | input | 1 | Serial data bit |
| match_o | output | 1 | Registered hit flag for the group just completed |

## Verification
The hardest case to reach from the ports is a hit state held across idle cycles and then left by a new valid bit. A second case is an accepted word that lies across a group boundary, which the block must not report. The stimulus inserts stretches with valid low right after a hit and in the middle of a group. It shifts the stream by one bit so that `1010` spans two groups. It also sends matching groups with no gap between them. A reference model that buffers four bits predicts the output on every cycle, and the bench checks the binary-coded and one-hot-coded builds together.

// File: rtl/frame_rec_pkg.sv
package frame_rec_pkg;
  localparam int GROUP_LEN = 4;
  localparam int POS_W     = $clog2(GROUP_LEN);
  localparam int N_STATES  = 8;
  localparam int STATE_W   = $clog2(N_STATES);

  // LIVE: group can still match; DEAD: ruled out but still counted
  typedef enum logic [STATE_W-1:0] {
    ST_START_MISS = 3'd0,
    ST_START_HIT  = 3'd1,
    ST_FIRST_ONE  = 3'd2,
    ST_FIRST_ZERO = 3'd3,
    ST_LIVE2      = 3'd4,
    ST_DEAD2      = 3'd5,
    ST_LIVE3      = 3'd6,
    ST_DEAD3      = 3'd7
  } rec_state_e;
endpackage

// File: rtl/frame_rec_next.sv
module frame_rec_next
  import frame_rec_pkg::*;
(
  input  rec_state_e cur_i,
  input  logic       bit_i,
  output rec_state_e nxt_o
);
  always_comb begin
    unique case (cur_i)
      ST_START_MISS,
      ST_START_HIT:  nxt_o = bit_i ? ST_FIRST_ONE : ST_FIRST_ZERO;
      ST_FIRST_ONE:  nxt_o = bit_i ? ST_DEAD2 : ST_LIVE2;
      ST_FIRST_ZERO: nxt_o = bit_i ? ST_LIVE2 : ST_DEAD2;
      ST_LIVE2:      nxt_o = bit_i ? ST_LIVE3 : ST_DEAD3;
      ST_DEAD2:      nxt_o = ST_DEAD3;
      ST_LIVE3:      nxt_o = bit_i ? ST_START_MISS : ST_START_HIT;
      ST_DEAD3:      nxt_o = ST_START_MISS;
      default:       nxt_o = ST_START_MISS;
    endcase
  end
endmodule

// File: rtl/frame_rec_state_reg.sv
module frame_rec_state_reg
  import frame_rec_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  rec_state_e nxt_i,
  output rec_state_e state_o
);
  if (ONE_HOT) begin : g_one_hot
    logic [N_STATES-1:0] oh_q, oh_nxt;
    logic [STATE_W-1:0]  idx;

    for (genvar i = 0; i < N_STATES; i++) begin : g_bit
      assign oh_nxt[i] = (nxt_i == rec_state_e'(STATE_W'(i)));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   oh_q <= N_STATES'(1) << ST_START_MISS;
      else if (en_i) oh_q <= oh_nxt;
    end

    always_comb begin
      idx = '0;
      for (int i = 0; i < N_STATES; i++)
        if (oh_q[i]) idx = idx | STATE_W'(i);
    end
    assign state_o = rec_state_e'(idx);

    a_r7_onehot_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(oh_q) == 1);
  end else begin : g_binary
    rec_state_e state_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   state_q <= ST_START_MISS;
      else if (en_i) state_q <= nxt_i;
    end
    assign state_o = state_q;
  end

  a_r7_state_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(state_o));
endmodule

// File: rtl/frame_pattern_recognizer.sv
module frame_pattern_recognizer
  import frame_rec_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  output logic match_o
);
  rec_state_e state, state_nxt;

  frame_rec_next i_next (
    .cur_i (state),
    .bit_i (bit_i),
    .nxt_o (state_nxt)
  );

  frame_rec_state_reg #(.ONE_HOT(ONE_HOT)) i_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (valid_i),
    .nxt_i   (state_nxt),
    .state_o (state)
  );

  // Moore output decoded from the hit-carrying start state
  assign match_o = (state == ST_START_HIT);

  // independent frame position, used by assertions only
  logic [POS_W-1:0] chk_pos_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chk_pos_q <= '0;
    else if (valid_i) chk_pos_q <= chk_pos_q + POS_W'(1);
  end

  a_r1_reset_low: assert property (@(posedge clk_i)
    !rst_ni |-> !match_o);
  a_r2_live_tail_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && state == ST_LIVE3 && !bit_i |=> match_o);
  a_r4_dead_never_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && state == ST_DEAD3 |=> !match_o);
  a_r5_hit_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> chk_pos_q == '0);
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o && valid_i |=> !match_o);
  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(match_o));
endmodule

// File: tb/test_frame_pattern_recognizer.sv
module test_frame_pattern_recognizer;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid = 1'b0;
  logic din = 1'b0;
  logic match_bin, match_oh;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [3:0] ref_grp = '0;
  int         ref_cnt = 0;
  logic       ref_exp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_pattern_recognizer #(.ONE_HOT(1'b0)) i_frame_pattern_recognizer (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .bit_i(din), .match_o(match_bin));

  frame_pattern_recognizer #(.ONE_HOT(1'b1)) i_frame_pattern_recognizer_oh (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .bit_i(din), .match_o(match_oh));

  task automatic check(input string tag, input logic exp);
    checks++;
    if (match_bin !== exp || match_oh !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual bin=%b oh=%b expected=%b",
               tag, $time, match_bin, match_oh, exp);
    end
  endtask

  task automatic send_bit(input logic b, input string tag);
    @(negedge clk);
    valid = 1'b1;
    din   = b;
    ref_grp = {ref_grp[2:0], b};
    ref_cnt++;
    if (ref_cnt == 4) begin
      ref_exp = (ref_grp == 4'b1010) || (ref_grp == 4'b0110);
      ref_cnt = 0;
    end else begin
      ref_exp = 1'b0;
    end
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(tag, ref_exp);
  endtask

  task automatic send_group(input logic [3:0] g, input string tag);
    for (int i = 3; i >= 0; i--) send_bit(g[i], tag);
  endtask

  task automatic idle(input int n, input string tag);
    @(negedge clk);
    valid = 1'b0;
    din   = ~din;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      check(tag, ref_exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    valid  = 1'b0;
    rst_ni = 1'b0;
    ref_grp = '0; ref_cnt = 0; ref_exp = 1'b0;
    #(CLK_PERIOD/4);
    check("R1 reset asserted", 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    #(CLK_PERIOD/4);
    check("R1 after release", 1'b0);
  endtask

  task automatic t_reset();
    check("R1 initial", 1'b0);
    apply_reset();
    send_bit(1'b1, "R1 partial");
    send_bit(1'b0, "R1 partial");
    apply_reset();
    send_group(4'b1010, "R1 new group after mid-group reset");
  endtask

  task automatic t_all_patterns();
    for (int p = 0; p < 16; p++) begin
      if (p == 4'b1010)      send_group(4'(p), "R2");
      else if (p == 4'b0110) send_group(4'(p), "R3");
      else                   send_group(4'(p), "R4");
    end
  endtask

  task automatic t_example();
    send_group(4'b0010, "R10");
    send_group(4'b0110, "R10");
    send_group(4'b1100, "R10");
    send_group(4'b1010, "R10");
    send_group(4'b0011, "R10");
  endtask

  task automatic t_misaligned();
    send_bit(1'b0, "R5 shift");
    send_group(4'b1010, "R5 straddle");
    send_bit(1'b1, "R5 shift");
    send_bit(1'b1, "R5 shift");
    send_bit(1'b0, "R5 shift");
  endtask

  task automatic t_dead_groups();
    send_group(4'b1100, "R8 dead");
    send_group(4'b1010, "R8 after dead");
    send_group(4'b0000, "R8 dead");
    send_group(4'b0110, "R8 after dead");
  endtask

  task automatic t_back_to_back();
    send_group(4'b1010, "R9");
    send_group(4'b0110, "R9");
    send_group(4'b1010, "R9");
  endtask

  task automatic t_valid_gaps();
    send_bit(1'b0, "R6");
    idle(3, "R7 mid-group idle");
    send_bit(1'b1, "R6");
    send_bit(1'b1, "R6");
    idle(2, "R7 mid-group idle");
    send_bit(1'b0, "R3 with gaps");
    idle(5, "R7 hit held");
    send_bit(1'b1, "R6 hit cleared");
    send_bit(1'b0, "R6");
    send_bit(1'b1, "R6");
    send_bit(1'b1, "R4 miss");
    idle(2, "R7 miss held");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_all_patterns();
    t_example();
    t_misaligned();
    t_dead_groups();
    t_back_to_back();
    t_valid_gaps();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule